// File: doc/BRIEF.md
# Set/Clear GPIO Controller with Interrupts

This block is a general-purpose I/O port of up to 32 lines behind a 32-bit memory-mapped register bus. Each control field has two write addresses. At the first address, a 1 in the write data sets that line's bit. At the second address, a 1 clears it. Several bus masters can therefore change single lines without read-modify-write races. A line drives its pad only when its direction bit selects output. Every input passes through a two-flop synchroniser. An optional per-line debounce filter follows the synchroniser.

Each line can raise an interrupt on a rising edge, a falling edge, a high level or a low level. A dual-edge mode overrides the edge and polarity settings and catches both edges. Edge events latch until an end-of-interrupt write clears them. Level matches are live. A per-line mask and a global gate decide which pending lines drive the single registered interrupt output.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: Write-1-to-set and write-1-to-clear addresses change only the bits written as 1; data bits written as 0 leave the register unchanged. Output data uses 0x000 (set) and 0x004 (clear). Direction uses 0x010 (set), 0x014 (clear) and 0x018 (state). A read of any set, clear or state address of a field returns that field's current value.
- R2: `pin_oe` equals the direction register (1 = output) and `pin_out` equals output data ANDed with direction. After reset every register is 0, so all lines are inputs, `pin_oe` is 0 and `pin_out` is 0.
- R3: Edge type (set 0x040, clear 0x044) 1 with polarity (set 0x050, clear 0x054) 1 latches a rising edge. Edge type 1 with polarity 0 latches a falling edge. The opposite edge does not latch. The latched bit appears in status (0x070) while the line's enable bit (set 0x020, clear 0x024) is 1.
- R4: Edge type 0 makes status follow the live level match (high when polarity is 1, low when polarity is 0), with no latching.
- R5: A line whose dual-edge bit (set 0x0B0, clear 0x0B4, state 0x0B8) is 1 latches both rising and falling edges, and its level detection is off, whatever its edge type and polarity hold.
- R6: Writing 1 to a bit of 0x078 clears that line's latched edge. Bits written 0 are unaffected.
- R7: A line with its mask bit set (set 0x030, clear 0x034) still shows status but does not drive `irq_out`.
- R8: `irq_out` is the registered OR over lines of status AND NOT mask, gated by bit 0 of 0x0A0. That bit is 0 after reset and reads back at bit 0.
- R9: Reading 0x080 returns the synchronised and filtered pin levels. A pin change is not visible to a read captured on the first three clock edges after it.
- R10: With a line's debounce bit set (set 0x060, clear 0x064), a new input level is accepted only after the synchronised input has held it for DEBOUNCE_CYCLES consecutive clocks. A shorter pulse is discarded.
- R11: Bits at and above NUM_LINES read as 0 and ignore writes.
- R12: A line whose enable bit is 0 shows status 0 and latches no edge. Enabling it later reveals no event from the disabled period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe for one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read strobe |
| pin_in | input | NUM_LINES | Asynchronous pad input levels |
| pin_out | output | NUM_LINES | Pad output levels |
| pin_oe | output | NUM_LINES | Pad output enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
A wrong latched-edge or enable state appears in the status read, and one clock later on `irq_out`. The edge cases therefore read status and then check the interrupt pin two cycles later. A debounce counter that is off by one shifts the cycle at which the external-port read flips. Reads are placed exactly on both sides of that cycle, and on both sides of the synchroniser delay. Stale mode state, such as a dual-edge bit that outlives its clear or a latch left by a disabled line, shows up as a status bit that is wrongly set on the next stimulus of the opposite kind.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

    localparam int REG_W = 32;

    localparam logic [7:0] OFS_DOUT_SET  = 8'h00;
    localparam logic [7:0] OFS_DOUT_CLR  = 8'h04;
    localparam logic [7:0] OFS_DIR_SET   = 8'h10;
    localparam logic [7:0] OFS_DIR_CLR   = 8'h14;
    localparam logic [7:0] OFS_DIR_ST    = 8'h18;
    localparam logic [7:0] OFS_IEN_SET   = 8'h20;
    localparam logic [7:0] OFS_IEN_CLR   = 8'h24;
    localparam logic [7:0] OFS_MSK_SET   = 8'h30;
    localparam logic [7:0] OFS_MSK_CLR   = 8'h34;
    localparam logic [7:0] OFS_TYP_SET   = 8'h40;
    localparam logic [7:0] OFS_TYP_CLR   = 8'h44;
    localparam logic [7:0] OFS_POL_SET   = 8'h50;
    localparam logic [7:0] OFS_POL_CLR   = 8'h54;
    localparam logic [7:0] OFS_DBN_SET   = 8'h60;
    localparam logic [7:0] OFS_DBN_CLR   = 8'h64;
    localparam logic [7:0] OFS_STATUS    = 8'h70;
    localparam logic [7:0] OFS_EOI       = 8'h78;
    localparam logic [7:0] OFS_EXT       = 8'h80;
    localparam logic [7:0] OFS_GATE      = 8'hA0;
    localparam logic [7:0] OFS_BOTH_SET  = 8'hB0;
    localparam logic [7:0] OFS_BOTH_CLR  = 8'hB4;
    localparam logic [7:0] OFS_BOTH_ST   = 8'hB8;

    typedef struct packed {
        logic [REG_W-1:0] dout;
        logic [REG_W-1:0] dir;
        logic [REG_W-1:0] ien;
        logic [REG_W-1:0] imask;
        logic [REG_W-1:0] itype;
        logic [REG_W-1:0] ipol;
        logic [REG_W-1:0] dbnc;
        logic [REG_W-1:0] both;
        logic             gate;
    } ctrl_regs_t;

endpackage

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
    parameter int NUM_LINES       = 32,
    parameter int DEBOUNCE_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_in,
    input  logic [NUM_LINES-1:0] dbnc_en,
    output logic [NUM_LINES-1:0] level_o
);

    localparam int CW = (DEBOUNCE_CYCLES < 2) ? 1 : $clog2(DEBOUNCE_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE_CYCLES - 1);

    typedef struct packed {
        logic [NUM_LINES-1:0]         s1;
        logic [NUM_LINES-1:0]         s2;
        logic [NUM_LINES-1:0]         flt;
        logic [NUM_LINES-1:0][CW-1:0] cnt;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_in;
        st_d.s2 = st_q.s1;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (!dbnc_en[i]) begin
                st_d.flt[i] = st_q.s2[i];
                st_d.cnt[i] = '0;
            end else if (st_q.s2[i] != st_q.flt[i]) begin
                if (st_q.cnt[i] == CNT_LAST) begin
                    st_d.flt[i] = st_q.s2[i];
                    st_d.cnt[i] = '0;
                end else begin
                    st_d.cnt[i] = st_q.cnt[i] + 1'b1;
                end
            end else begin
                st_d.cnt[i] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.flt;

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line_chk
        // R9: a filtered level only ever takes the synchronised value
        assert_flt_from_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.flt[gi] != $past(st_q.flt[gi])) |-> (st_q.flt[gi] == $past(st_q.s2[gi])));
        // R10: with debounce on, a change needs a full hold count
        assert_debounce_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(dbnc_en[gi]) && (st_q.flt[gi] != $past(st_q.flt[gi])))
            |-> ($past(st_q.cnt[gi]) == CNT_LAST));
    end

endmodule

// File: rtl/gpio_irq_engine.sv
module gpio_irq_engine #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] level_i,
    input  logic [NUM_LINES-1:0] ien,
    input  logic [NUM_LINES-1:0] itype,
    input  logic [NUM_LINES-1:0] ipol,
    input  logic [NUM_LINES-1:0] both,
    input  logic [NUM_LINES-1:0] eoi,
    output logic [NUM_LINES-1:0] status_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] prev;
        logic [NUM_LINES-1:0] latch;
    } eng_state_t;

    eng_state_t st_d, st_q;

    logic [NUM_LINES-1:0] rise, fall, sel_edge, ev, lvl_hit;

    always_comb begin
        rise     = level_i & ~st_q.prev;
        fall     = ~level_i & st_q.prev;
        sel_edge = (ipol & rise) | (~ipol & fall);
        ev       = ien & ((both & (rise | fall)) | (~both & itype & sel_edge));
        lvl_hit  = ien & ~both & ~itype & ~(level_i ^ ipol);
    end

    always_comb begin
        st_d       = st_q;
        st_d.prev  = level_i;
        st_d.latch = (st_q.latch & ~eoi) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = ien & (st_q.latch | lvl_hit);

    // R6: acknowledged lines without a new event are clear next cycle
    assert_eoi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(eoi & ~ev)) |=> ((st_q.latch & $past(eoi & ~ev)) == '0));
    // R12: a latch never rises on a line that was disabled
    assert_no_latch_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.latch & ~$past(st_q.latch) & ~$past(ien)) == '0));
    // R5: in dual-edge mode every edge on an enabled line latches
    assert_both_edges_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ien & both & (rise | fall)))
        |=> ((st_q.latch & $past(ien & both & (rise | fall))) == $past(ien & both & (rise | fall))));

endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_LINES       = 32,
    parameter int DEBOUNCE_CYCLES = 8,
    parameter int ADDR_W          = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic                 irq_out
);

    localparam logic [REG_W:0]   ONE_EXT   = (REG_W+1)'(1) << NUM_LINES;
    localparam logic [REG_W-1:0] LINE_MASK = REG_W'(ONE_EXT - 1'b1);

    localparam logic [ADDR_W-1:0] A_DOUT_SET = ADDR_W'(OFS_DOUT_SET);
    localparam logic [ADDR_W-1:0] A_DOUT_CLR = ADDR_W'(OFS_DOUT_CLR);
    localparam logic [ADDR_W-1:0] A_DIR_SET  = ADDR_W'(OFS_DIR_SET);
    localparam logic [ADDR_W-1:0] A_DIR_CLR  = ADDR_W'(OFS_DIR_CLR);
    localparam logic [ADDR_W-1:0] A_DIR_ST   = ADDR_W'(OFS_DIR_ST);
    localparam logic [ADDR_W-1:0] A_IEN_SET  = ADDR_W'(OFS_IEN_SET);
    localparam logic [ADDR_W-1:0] A_IEN_CLR  = ADDR_W'(OFS_IEN_CLR);
    localparam logic [ADDR_W-1:0] A_MSK_SET  = ADDR_W'(OFS_MSK_SET);
    localparam logic [ADDR_W-1:0] A_MSK_CLR  = ADDR_W'(OFS_MSK_CLR);
    localparam logic [ADDR_W-1:0] A_TYP_SET  = ADDR_W'(OFS_TYP_SET);
    localparam logic [ADDR_W-1:0] A_TYP_CLR  = ADDR_W'(OFS_TYP_CLR);
    localparam logic [ADDR_W-1:0] A_POL_SET  = ADDR_W'(OFS_POL_SET);
    localparam logic [ADDR_W-1:0] A_POL_CLR  = ADDR_W'(OFS_POL_CLR);
    localparam logic [ADDR_W-1:0] A_DBN_SET  = ADDR_W'(OFS_DBN_SET);
    localparam logic [ADDR_W-1:0] A_DBN_CLR  = ADDR_W'(OFS_DBN_CLR);
    localparam logic [ADDR_W-1:0] A_STATUS   = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_EOI      = ADDR_W'(OFS_EOI);
    localparam logic [ADDR_W-1:0] A_EXT      = ADDR_W'(OFS_EXT);
    localparam logic [ADDR_W-1:0] A_GATE     = ADDR_W'(OFS_GATE);
    localparam logic [ADDR_W-1:0] A_BOTH_SET = ADDR_W'(OFS_BOTH_SET);
    localparam logic [ADDR_W-1:0] A_BOTH_CLR = ADDR_W'(OFS_BOTH_CLR);
    localparam logic [ADDR_W-1:0] A_BOTH_ST  = ADDR_W'(OFS_BOTH_ST);

    typedef struct packed {
        ctrl_regs_t       ctl;
        logic [REG_W-1:0] rdata;
        logic             irq;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                 wr_en, rd_en;
    logic [REG_W-1:0]     wr_bits;
    logic [REG_W-1:0]     eoi_bits;
    logic [NUM_LINES-1:0] level_w;
    logic [NUM_LINES-1:0] status_n;
    logic [REG_W-1:0]     status_w;
    logic [REG_W-1:0]     ext_w;

    assign wr_en   = bus_valid & bus_write;
    assign rd_en   = bus_valid & ~bus_write;
    assign wr_bits = wr_en ? (bus_wdata & LINE_MASK) : '0;

    always_comb begin
        eoi_bits = '0;
        if (wr_en && (bus_addr == A_EOI)) eoi_bits = wr_bits;
    end

    always_comb begin
        status_w                  = '0;
        status_w[NUM_LINES-1:0]   = status_n;
        ext_w                     = '0;
        ext_w[NUM_LINES-1:0]      = level_w;
    end

    gpio_in_filter #(
        .NUM_LINES       (NUM_LINES),
        .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
    ) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .dbnc_en (st_q.ctl.dbnc[NUM_LINES-1:0]),
        .level_o (level_w)
    );

    gpio_irq_engine #(
        .NUM_LINES (NUM_LINES)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (level_w),
        .ien      (st_q.ctl.ien[NUM_LINES-1:0]),
        .itype    (st_q.ctl.itype[NUM_LINES-1:0]),
        .ipol     (st_q.ctl.ipol[NUM_LINES-1:0]),
        .both     (st_q.ctl.both[NUM_LINES-1:0]),
        .eoi      (eoi_bits[NUM_LINES-1:0]),
        .status_o (status_n)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (bus_addr)
                A_DOUT_SET: st_d.ctl.dout  = st_q.ctl.dout  |  wr_bits;
                A_DOUT_CLR: st_d.ctl.dout  = st_q.ctl.dout  & ~wr_bits;
                A_DIR_SET:  st_d.ctl.dir   = st_q.ctl.dir   |  wr_bits;
                A_DIR_CLR:  st_d.ctl.dir   = st_q.ctl.dir   & ~wr_bits;
                A_IEN_SET:  st_d.ctl.ien   = st_q.ctl.ien   |  wr_bits;
                A_IEN_CLR:  st_d.ctl.ien   = st_q.ctl.ien   & ~wr_bits;
                A_MSK_SET:  st_d.ctl.imask = st_q.ctl.imask |  wr_bits;
                A_MSK_CLR:  st_d.ctl.imask = st_q.ctl.imask & ~wr_bits;
                A_TYP_SET:  st_d.ctl.itype = st_q.ctl.itype |  wr_bits;
                A_TYP_CLR:  st_d.ctl.itype = st_q.ctl.itype & ~wr_bits;
                A_POL_SET:  st_d.ctl.ipol  = st_q.ctl.ipol  |  wr_bits;
                A_POL_CLR:  st_d.ctl.ipol  = st_q.ctl.ipol  & ~wr_bits;
                A_DBN_SET:  st_d.ctl.dbnc  = st_q.ctl.dbnc  |  wr_bits;
                A_DBN_CLR:  st_d.ctl.dbnc  = st_q.ctl.dbnc  & ~wr_bits;
                A_BOTH_SET: st_d.ctl.both  = st_q.ctl.both  |  wr_bits;
                A_BOTH_CLR: st_d.ctl.both  = st_q.ctl.both  & ~wr_bits;
                A_GATE:     st_d.ctl.gate  = bus_wdata[0];
                default: ;
            endcase
        end
        if (rd_en) begin
            case (bus_addr)
                A_DOUT_SET, A_DOUT_CLR:           st_d.rdata = st_q.ctl.dout;
                A_DIR_SET, A_DIR_CLR, A_DIR_ST:   st_d.rdata = st_q.ctl.dir;
                A_IEN_SET, A_IEN_CLR:             st_d.rdata = st_q.ctl.ien;
                A_MSK_SET, A_MSK_CLR:             st_d.rdata = st_q.ctl.imask;
                A_TYP_SET, A_TYP_CLR:             st_d.rdata = st_q.ctl.itype;
                A_POL_SET, A_POL_CLR:             st_d.rdata = st_q.ctl.ipol;
                A_DBN_SET, A_DBN_CLR:             st_d.rdata = st_q.ctl.dbnc;
                A_BOTH_SET, A_BOTH_CLR, A_BOTH_ST: st_d.rdata = st_q.ctl.both;
                A_STATUS:                         st_d.rdata = status_w;
                A_EXT:                            st_d.rdata = ext_w;
                A_GATE:                           st_d.rdata = {{(REG_W-1){1'b0}}, st_q.ctl.gate};
                default:                          st_d.rdata = '0;
            endcase
        end
        st_d.irq = st_q.ctl.gate & (|(status_w & ~st_q.ctl.imask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign pin_oe    = st_q.ctl.dir[NUM_LINES-1:0];
    assign pin_out   = st_q.ctl.dout[NUM_LINES-1:0] & st_q.ctl.dir[NUM_LINES-1:0];
    assign irq_out   = st_q.irq;

    // R8: the combined interrupt only follows a cycle with the gate open
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(st_q.ctl.gate));

    if (NUM_LINES < REG_W) begin : g_high_chk
        // R11: nothing above the implemented lines is ever returned
        assert_high_bits_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[REG_W-1:NUM_LINES] == '0);
    end

endmodule

// File: tb/gpio_setclr_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_setclr_ctrl_bench;

    localparam int NL  = 24;
    localparam int DBC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pin_in = '0;
    logic [NL-1:0] pin_out;
    logic [NL-1:0] pin_oe;
    logic          irq_out;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;

    gpio_setclr_ctrl #(
        .NUM_LINES       (NL),
        .DEBOUNCE_CYCLES (DBC),
        .ADDR_W          (8)
    ) u_gpio_setclr_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_out   (irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: compares each returned read with the queued expectation
    always @(posedge clk) rd_seen <= rst_n && bus_valid && !bus_write;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL scoreboard read without expectation actual=0x%08h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    // drivers are called at a falling edge and return at the next one
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R2 reset pin_oe", 32'(pin_oe), 32'h0);
        chk("R2 reset pin_out", 32'(pin_out), 32'h0);
        chk("R8 reset irq_out", 32'(irq_out), 32'h0);
        rd(8'h18, 32'h0, "R2 reset direction");
        rd(8'h70, 32'h0, "R12 reset status");
        rd(8'hA0, 32'h0, "R8 reset gate");

        // set/clear semantics and pad drive
        wr(8'h10, 32'h0000_00F0);
        wr(8'h00, 32'h0000_0FF0);
        rd(8'h00, 32'h0000_0FF0, "R1 dout after set");
        rd(8'h18, 32'h0000_00F0, "R1 dir state");
        chk("R2 pin_out gated by dir", 32'(pin_out), 32'h0000_00F0);
        chk("R2 pin_oe equals dir", 32'(pin_oe), 32'h0000_00F0);
        wr(8'h04, 32'h0000_0030);
        rd(8'h04, 32'h0000_0FC0, "R1 dout after clear");
        chk("R2 pin_out after clear", 32'(pin_out), 32'h0000_00C0);
        wr(8'h14, 32'h0000_0000);
        rd(8'h14, 32'h0000_00F0, "R1 zero clear no effect");
        wr(8'h10, 32'hFF00_0000);
        rd(8'h18, 32'h0000_00F0, "R11 high dir bits ignored");
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h00FF_FFFF, "R11 dout high bits read zero");
        chk("R2 inputs do not drive", 32'(pin_out), 32'h0);
        wr(8'h04, 32'hFFFF_FFFF);

        // synchroniser latency
        pin_in = 24'h12_A55A;
        rd(8'h80, 32'h0, "R9 ext not yet visible");
        idle(3);
        rd(8'h80, 32'h0012_A55A, "R9 ext synchronised");
        pin_in = '0;
        idle(4);
        rd(8'h80, 32'h0, "R9 ext back to zero");

        wr(8'hA0, 32'h1);
        rd(8'hA0, 32'h1, "R8 gate readback");

        // rising edge on line 0
        wr(8'h40, 32'h1); wr(8'h50, 32'h1); wr(8'h20, 32'h1);
        pin_in[0] = 1'b1;
        idle(5);
        rd(8'h70, 32'h1, "R3 rising latched");
        chk("R8 irq on pending line", 32'(irq_out), 32'h1);
        pin_in[0] = 1'b0;
        idle(5);
        rd(8'h70, 32'h1, "R3 edge held after pin falls");
        wr(8'h78, 32'h1);
        rd(8'h70, 32'h0, "R6 eoi clears");
        idle(1);
        chk("R6 irq drops after eoi", 32'(irq_out), 32'h0);

        // falling edge on line 1
        wr(8'h40, 32'h2); wr(8'h54, 32'h2); wr(8'h20, 32'h2);
        pin_in[1] = 1'b1;
        idle(5);
        rd(8'h70, 32'h0, "R3 falling type ignores rise");
        pin_in[1] = 1'b0;
        idle(5);
        rd(8'h70, 32'h2, "R3 falling latched");
        wr(8'h78, 32'h0);
        rd(8'h70, 32'h2, "R6 zero eoi no effect");
        wr(8'h78, 32'h2);
        rd(8'h70, 32'h0, "R6 eoi clears line 1");

        // level high on line 2
        wr(8'h50, 32'h4); wr(8'h20, 32'h4);
        idle(2);
        rd(8'h70, 32'h0, "R4 level high inactive");
        pin_in[2] = 1'b1;
        idle(4);
        rd(8'h70, 32'h4, "R4 level high active");
        pin_in[2] = 1'b0;
        idle(4);
        rd(8'h70, 32'h0, "R4 level not latched");
        wr(8'h24, 32'h4);

        // per-line mask and global gate
        wr(8'h30, 32'h1);
        pin_in[0] = 1'b1;
        idle(5);
        rd(8'h70, 32'h1, "R7 masked status still latches");
        chk("R7 masked line no irq", 32'(irq_out), 32'h0);
        wr(8'h34, 32'h1);
        idle(1);
        chk("R7 unmask raises irq", 32'(irq_out), 32'h1);
        wr(8'hA0, 32'h0);
        idle(1);
        chk("R8 gate closed blocks irq", 32'(irq_out), 32'h0);
        wr(8'hA0, 32'h1);
        idle(1);
        chk("R8 gate reopened", 32'(irq_out), 32'h1);
        wr(8'h78, 32'h1);
        pin_in[0] = 1'b0;
        idle(5);
        rd(8'h70, 32'h0, "R3 rising type ignores fall");

        // dual-edge on line 1 (falling type underneath)
        wr(8'hB0, 32'h2);
        rd(8'hB8, 32'h2, "R5 dual-edge state");
        pin_in[1] = 1'b1;
        idle(5);
        rd(8'h70, 32'h2, "R5 dual-edge catches rise");
        wr(8'h78, 32'h2);
        pin_in[1] = 1'b0;
        idle(5);
        rd(8'h70, 32'h2, "R5 dual-edge catches fall");
        wr(8'h78, 32'h2);
        wr(8'hB4, 32'h2);
        rd(8'hB8, 32'h0, "R5 dual-edge cleared");
        pin_in[1] = 1'b1;
        idle(5);
        rd(8'h70, 32'h0, "R5 falling type restored");
        pin_in[1] = 1'b0;
        idle(5);
        wr(8'h78, 32'h2);

        // dual-edge overrides level-high on line 2
        wr(8'hB0, 32'h4); wr(8'h20, 32'h4);
        pin_in[2] = 1'b1;
        idle(5);
        rd(8'h70, 32'h4, "R5 dual-edge rise on level line");
        wr(8'h78, 32'h4);
        rd(8'h70, 32'h0, "R5 level match suppressed");
        wr(8'hB4, 32'h4);
        rd(8'h70, 32'h4, "R4 level resumes after dual-edge clear");
        wr(8'h24, 32'h4);
        pin_in[2] = 1'b0;
        idle(4);

        // disabled line latches nothing
        wr(8'h40, 32'h8); wr(8'h50, 32'h8);
        pin_in[3] = 1'b1;
        idle(5);
        rd(8'h70, 32'h0, "R12 disabled line no status");
        wr(8'h20, 32'h8);
        rd(8'h70, 32'h0, "R12 no stale latch on enable");
        pin_in[3] = 1'b0;
        idle(5);
        pin_in[3] = 1'b1;
        idle(5);
        rd(8'h70, 32'h8, "R3 enabled line latches");
        wr(8'h78, 32'h8);
        wr(8'h24, 32'h8);
        pin_in[3] = 1'b0;
        idle(4);

        // debounce on line 4
        wr(8'h60, 32'h10);
        rd(8'h60, 32'h10, "R10 debounce state");
        pin_in[4] = 1'b1;
        idle(DBC - 1);
        pin_in[4] = 1'b0;
        idle(10);
        rd(8'h80, 32'h0, "R10 short pulse rejected");
        pin_in[4] = 1'b1;
        idle(DBC + 1);
        rd(8'h80, 32'h0, "R10 not yet accepted");
        rd(8'h80, 32'h10, "R10 accepted after hold");
        wr(8'h64, 32'h10);
        rd(8'h64, 32'h0, "R10 debounce cleared");
        pin_in[4] = 1'b0;
        idle(4);
        rd(8'h80, 32'h0, "R9 undebounced follows");

        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule